// File: doc/BRIEF.md
# Millihertz-step DDS phase engine

This block is the phase engine of a direct digital synthesis generator. A counter divides the fast system clock into a single-cycle update strobe. On each strobe the engine adds a 32-bit tuning word, plus an optional one-shot phase offset, to a phase accumulator. The accumulator wraps modulo 3406 × 2^20 instead of a power of two. With a 25 MHz system clock and a divide-by-7 strobe, one tuning-word count then gives an output step of very nearly one millihertz (about 0.000999994 Hz). The top bits of the phase, the phase divided by 2^20, form a 12-bit index into a 3406-entry waveform table. The engine also holds a 17-bit signed amplitude word for a downstream multiplier.

Settings arrive from a command front end as a 2-bit request code and a 32-bit value. The engine samples them on every update strobe and answers with an accepted flag. The requester keeps its code asserted until it sees the flag, then drops it. After reset the engine waits a fixed number of strobes before it runs. During this wait the phase stays frozen, commands are not taken, and power-on defaults are loaded: a tuning word of 1000006 (about 1 kHz), an amplitude of 32768, and no offset.

Top module: `dds_phase_engine`

## Requirements
- R1: `step_tick` is high for exactly one cycle in every 7 system clocks. Its first pulse is in the 7th cycle after reset is released.
- R2: While reset is high and in the cycle after it is released, `table_index`, `amplitude`, `cmd_accept` and `step_tick` are all 0.
- R3: Across the first 255 strobes after reset the phase stays at 0, so `table_index` stays 0. `cmd_accept` stays 0 and any request is ignored. Each of these strobes loads the defaults: tuning 1000006, amplitude 32768 and offset 0.
- R4: From the 256th strobe on, every strobe sets phase = (phase + tuning + offset) mod 3571449856. `table_index` equals phase >> 20, is always below 3406, changes only at a strobe edge, and shows the new value in the cycle after `step_tick`.
- R5: A tuning or phase value at or above 3571449856 has 3571449856 subtracted once when it is loaded. Smaller values are stored unchanged.
- R6: Request codes are 0 = none, 1 = tuning word, 2 = phase offset and 3 = amplitude. On each running strobe `cmd_accept` becomes 1 if the code is nonzero and 0 if it is zero. It changes at no other time.
- R7: A tuning word loaded on one strobe is first used in the phase update of the next strobe.
- R8: A phase offset loaded on one strobe is added in the update of the next strobe only. Any strobe whose code is not 2 clears the offset.
- R9: An amplitude request stores {1'b0, value[15:0]}; value bits 31:16 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 2 | Request code: 0 none, 1 tuning, 2 phase offset, 3 amplitude |
| cmd_value | input | 32 | Value carried with the request |
| cmd_accept | output | 1 | High after a strobe that took a request |
| step_tick | output | 1 | Single-cycle update strobe |
| table_index | output | 12 | Waveform table index, phase >> 20 |
| amplitude | output | 17 | Signed amplitude word for the output multiplier |

## Verification
The hardest case to reach is a phase update where both the tuning word and the one-shot offset are close to the modulus while the phase is already near its top. Only then do both fold stages of the wrap subtract in the same update. The stimulus gets there in two steps. A directed sequence first loads a tuning word of modulus − 1 and then an offset of modulus − 1. The random phase then draws values from a list of corners around the modulus and around 2^32, besides uniform words. The 255-strobe start-up window is also covered: requests are held during the wait and the bench shows that none is taken.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Request codes carried on the command port
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_FREQ  = 2'd1,
    CMD_PHASE = 2'd2,
    CMD_AMP   = 2'd3
  } cmd_e;

  // Default geometry of the engine
  localparam int unsigned DEF_TABLE_LEN  = 3406;
  localparam int unsigned DEF_FRAC_BITS  = 20;
  localparam int unsigned DEF_PHASE_W    = 32;
  localparam int unsigned DEF_DATA_W     = 16;
  localparam int unsigned DEF_STEP_DIV   = 7;
  localparam int unsigned DEF_WAIT_STEPS = 255;

endpackage

// File: rtl/dds_step_timer.sv
module dds_step_timer #(
  parameter int DIV = 7
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end

  // Checker: spacing between strobes, measured with its own counter
  logic [CW:0] gap;
  logic        seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + (CW+1)'(1);
    end
  end

  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  p_tick_period_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> (gap == (CW+1)'(DIV - 1)));

endmodule

// File: rtl/dds_startup.sv
module dds_startup #(
  parameter int WAIT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic running
);
  localparam int CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] LAST_WAIT = CW'(WAIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (tick && !running) begin
      cnt <= cnt + CW'(1);
      if (cnt == LAST_WAIT) running <= 1'b1;
    end
  end

  p_running_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
  p_start_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!running && !tick) |=> !running);

endmodule

// File: rtl/dds_cmd_regs.sv
module dds_cmd_regs import dds_pkg::*; #(
  parameter int          PHASE_W     = 32,
  parameter int          TABLE_LEN   = 3406,
  parameter int          FRAC_BITS   = 20,
  parameter int          DATA_W      = 16,
  parameter int unsigned TW_DEFAULT  = 1000006,
  parameter int unsigned AMP_DEFAULT = 32768
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               running,
  input  logic [1:0]         cmd_code,
  input  logic [PHASE_W-1:0] cmd_value,
  output logic [PHASE_W-1:0] tuning,
  output logic [PHASE_W-1:0] offset,
  output logic [DATA_W:0]    amplitude,
  output logic               accept
);
  localparam int ACC_W = PHASE_W + 1;
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(TABLE_LEN) << FRAC_BITS;

  cmd_e code;
  assign code = cmd_e'(cmd_code);

  // Bring a value into [0, modulus) with one conditional subtraction
  function automatic logic [PHASE_W-1:0] fold(input logic [PHASE_W-1:0] v);
    if ({1'b0, v} >= MODULUS) return v - MODULUS[PHASE_W-1:0];
    else                      return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tuning    <= '0;
      offset    <= '0;
      amplitude <= '0;
      accept    <= 1'b0;
    end else if (tick) begin
      if (!running) begin
        tuning    <= PHASE_W'(TW_DEFAULT);
        amplitude <= (DATA_W+1)'(AMP_DEFAULT);
        offset    <= '0;
        accept    <= 1'b0;
      end else begin
        accept <= (code != CMD_NONE);
        offset <= '0;
        case (code)
          CMD_FREQ:  tuning    <= fold(cmd_value);
          CMD_PHASE: offset    <= fold(cmd_value);
          CMD_AMP:   amplitude <= {1'b0, cmd_value[DATA_W-1:0]};
          default:   ;
        endcase
      end
    end
  end

  p_accept_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(accept));
  p_wait_no_accept_r3: assert property (@(posedge clk) disable iff (rst)
    !running |-> !accept);
  p_offset_one_shot_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && running && code != CMD_PHASE) |=> (offset == '0));
  p_tuning_folded_r5: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, tuning} < MODULUS) && ({1'b0, offset} < MODULUS));
  p_amp_sign_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !amplitude[DATA_W]);

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int PHASE_W   = 32,
  parameter int TABLE_LEN = 3406,
  parameter int FRAC_BITS = 20,
  parameter int IDX_W     = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               running,
  input  logic [PHASE_W-1:0] tuning,
  input  logic [PHASE_W-1:0] offset,
  output logic [IDX_W-1:0]   index
);
  localparam int ACC_W = PHASE_W + 1;
  localparam int N_ADD = 2;
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(TABLE_LEN) << FRAC_BITS;
  localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(TABLE_LEN);

  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] nxt;
  logic [PHASE_W-1:0] addend [N_ADD];
  logic [ACC_W-1:0]   sum;

  assign addend[0] = tuning;
  assign addend[1] = offset;

  // One compare-and-subtract stage per addend; each input is already below
  // the modulus, so every stage result stays below it too.
  always_comb begin
    nxt = acc;
    sum = '0;
    for (int k = 0; k < N_ADD; k++) begin
      sum = {1'b0, nxt} + {1'b0, addend[k]};
      if (sum >= MODULUS) nxt = sum[PHASE_W-1:0] - MODULUS[PHASE_W-1:0];
      else                nxt = sum[PHASE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      index <= '0;
    end else if (tick && running) begin
      acc   <= nxt;
      index <= nxt[FRAC_BITS +: IDX_W];
    end
  end

  p_phase_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc} < MODULUS);
  p_index_range_r4: assert property (@(posedge clk) disable iff (rst)
    index < IDX_LIMIT);
  p_index_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(index));
  p_frozen_wait_r3: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(acc));

endmodule

// File: rtl/dds_phase_engine.sv
module dds_phase_engine import dds_pkg::*; #(
  parameter int          STEP_DIV    = 7,
  parameter int          WAIT_STEPS  = 255,
  parameter int          TABLE_LEN   = 3406,
  parameter int          FRAC_BITS   = 20,
  parameter int          PHASE_W     = 32,
  parameter int          DATA_W      = 16,
  parameter int unsigned TW_DEFAULT  = 1000006,
  parameter int unsigned AMP_DEFAULT = 32768,
  localparam int         IDX_W       = $clog2(TABLE_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmd_code,
  input  logic [PHASE_W-1:0] cmd_value,
  output logic               cmd_accept,
  output logic               step_tick,
  output logic [IDX_W-1:0]   table_index,
  output logic [DATA_W:0]    amplitude
);
  logic               running;
  logic [PHASE_W-1:0] tuning;
  logic [PHASE_W-1:0] offset;

  dds_step_timer #(.DIV(STEP_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (step_tick)
  );

  dds_startup #(.WAIT(WAIT_STEPS)) u_startup (
    .clk     (clk),
    .rst     (rst),
    .tick    (step_tick),
    .running (running)
  );

  dds_cmd_regs #(
    .PHASE_W     (PHASE_W),
    .TABLE_LEN   (TABLE_LEN),
    .FRAC_BITS   (FRAC_BITS),
    .DATA_W      (DATA_W),
    .TW_DEFAULT  (TW_DEFAULT),
    .AMP_DEFAULT (AMP_DEFAULT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .tick      (step_tick),
    .running   (running),
    .cmd_code  (cmd_code),
    .cmd_value (cmd_value),
    .tuning    (tuning),
    .offset    (offset),
    .amplitude (amplitude),
    .accept    (cmd_accept)
  );

  dds_phase_core #(
    .PHASE_W   (PHASE_W),
    .TABLE_LEN (TABLE_LEN),
    .FRAC_BITS (FRAC_BITS),
    .IDX_W     (IDX_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (step_tick),
    .running (running),
    .tuning  (tuning),
    .offset  (offset),
    .index   (table_index)
  );

endmodule

// File: tb/test_dds_phase_engine.sv
module test_dds_phase_engine;

  localparam longint unsigned MODV = 64'd3406 << 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd_code = 2'd0;
  logic [31:0] cmd_value = 32'd0;
  logic        cmd_accept;
  logic        step_tick;
  logic [11:0] table_index;
  logic [16:0] amplitude;

  dds_phase_engine i_dds_phase_engine (
    .clk         (clk),
    .rst         (rst),
    .cmd_code    (cmd_code),
    .cmd_value   (cmd_value),
    .cmd_accept  (cmd_accept),
    .step_tick   (step_tick),
    .table_index (table_index),
    .amplitude   (amplitude)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cyc    = 0;
  int last_tick = -1;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference state
  longint unsigned m_phase = 0, m_tune = 0, m_off = 0, m_amp = 0;
  bit m_accept = 1'b0;
  int m_waits  = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned fold(input logic [31:0] v);
    return 64'(v) % MODV;
  endfunction

  task automatic model_update();
    if (m_waits < 255) begin
      m_tune = 1000006; m_amp = 32768; m_off = 0; m_accept = 1'b0;
      m_waits++;
    end else begin
      m_phase  = (m_phase + m_tune + m_off) % MODV;
      m_accept = (cmd_code != 2'd0);
      m_off    = 0;
      case (cmd_code)
        2'd1: m_tune = fold(cmd_value);
        2'd2: m_off  = fold(cmd_value);
        2'd3: m_amp  = 64'(cmd_value[15:0]);
        default: ;
      endcase
    end
  endtask

  // Wait for the next strobe, update the model, then compare outputs
  task automatic step();
    @(negedge clk);
    while (!step_tick) @(negedge clk);
    if (last_tick >= 0) check("R1 strobe period", 64'(cyc - last_tick), 64'd7);
    last_tick = cyc;
    model_update();
    @(negedge clk);
    check("R4/R3 table_index", 64'(table_index), m_phase >> 20);
    check("R4 index below 3406", 64'(table_index < 12'd3406), 64'd1);
    check("R6 cmd_accept", 64'(cmd_accept), 64'(m_accept));
    check("R9 amplitude", 64'(amplitude), m_amp);
    check("R1 strobe single cycle", 64'(step_tick), 64'd0);
  endtask

  task automatic request(input logic [1:0] c, input logic [31:0] v);
    cmd_code = c; cmd_value = v;
    step();
    cmd_code = 2'd0;
  endtask

  initial begin
    int n;
    logic [31:0] corners [8];
    corners[0] = 32'(MODV - 1); corners[1] = 32'(MODV);     corners[2] = 32'(MODV + 1);
    corners[3] = 32'hFFFF_FFFF; corners[4] = 32'd0;         corners[5] = 32'd1;
    corners[6] = 32'd3348234240; corners[7] = 32'(MODV - 64'd1048576);
    void'($urandom(32'd20250611));

    repeat (4) @(negedge clk);
    check("R2 index in reset", 64'(table_index), 64'd0);
    check("R2 amplitude in reset", 64'(amplitude), 64'd0);
    check("R2 accept in reset", 64'(cmd_accept), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 strobe after reset", 64'(step_tick), 64'd0);
    check("R2 amplitude after reset", 64'(amplitude), 64'd0);
    // R1: first strobe lands 7 cycles after release
    n = 1;
    while (!step_tick) begin @(negedge clk); n++; end
    check("R1 first strobe delay", 64'(n), 64'd7);
    last_tick = cyc;
    model_update();
    @(negedge clk);
    check("R3 default amplitude", 64'(amplitude), 64'd32768);
    check("R3 index frozen", 64'(table_index), 64'd0);

    // R3: start-up window, requests held and ignored
    for (int k = 2; k <= 255; k++) begin
      if (k >= 10 && k <= 20) begin cmd_code = 2'd3; cmd_value = 32'd100; end
      else if (k >= 30 && k <= 35) begin cmd_code = 2'd1; cmd_value = 32'd5000000; end
      else cmd_code = 2'd0;
      step();
    end
    cmd_code = 2'd0;
    check("R3 accept still low after wait", 64'(cmd_accept), 64'd0);

    // R4/R7: default tuning word runs
    step(); step();
    check("R7 default tuning drives phase", 64'(table_index), (64'd2 * 1000006) >> 20);

    // R5 boundary: modulus - 1 stored as is, then used next update (R7)
    request(2'd1, 32'(MODV - 1));
    step(); step();
    // R8 double fold: offset of modulus - 1 with phase near the top
    request(2'd2, 32'(MODV - 1));
    step(); step();
    // R5: 2^32 - 1 and exactly the modulus are folded
    request(2'd1, 32'hFFFF_FFFF); step(); step();
    request(2'd1, 32'(MODV));     step(); step();
    check("R5 modulus folds to zero step", 64'(table_index), m_phase >> 20);
    // R8: minus 22.5 degrees, applied once
    request(2'd1, 32'd1000000); step();
    request(2'd2, 32'd3348234240); step(); step();
    request(2'd2, 32'(MODV + 5)); step();
    // R8: offset held for two strobes applies twice, then a tuning request clears it
    cmd_code = 2'd2; cmd_value = 32'd892862464; step(); step();
    cmd_code = 2'd1; cmd_value = 32'd440000; step();
    cmd_code = 2'd0; step(); step();
    // R9: amplitude field
    request(2'd3, 32'd32767);    step();
    request(2'd3, 32'h0001_2345); step();
    check("R9 upper bits ignored", 64'(amplitude), 64'h2345);
    request(2'd3, 32'h0000_FFFF); step();
    request(2'd3, 32'd0);         step();

    // Constrained random mix
    for (int it = 0; it < 500; it++) begin
      logic [1:0]  c;
      logic [31:0] v;
      c = 2'($urandom_range(0, 3));
      v = ($urandom_range(0, 3) == 0) ? corners[$urandom_range(0, 7)] : $urandom;
      cmd_code = c; cmd_value = v;
      step();
      if ($urandom_range(0, 4) == 0) step();
      cmd_code = 2'd0;
      repeat ($urandom_range(1, 2)) step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule